// File: doc/BRIEF.md
# Offset and Fine-Gain Calibration Sequencer

This block trims an image-sensor digitizer by stepping two external trim DACs, one that shifts the black level and one that scales the converter's full scale. It watches the converted sample stream, averages a fixed number of valid samples per trial, and moves the active trim word by a binary-search step. The step halves each time the search changes direction. Codes are straight binary, and a positive step on either trim raises the code.

Calibration always runs in a fixed order. First comes the black-level pass, with a dark input applied; it aims for code 0 with the least significant bit flickering. The sequencer then parks and waits for a one-cycle `host_ready` pulse, which gives the host time to switch the input to a saturated level. Next comes the full-scale pass, which aims for all ones (16383 at 14 bits) with the least significant bit flickering. `cal_done` is raised on success. `cal_fail` is raised when a trim word is pinned at its range limit and the search still pushes it outward.

Top module: `calib_seq`

## Requirements
- R1: After reset both trim words are 0, `cal_done` and `cal_fail` are 0, and `cal_phase` is 0.
- R2: `cal_phase` encodes 0 idle, 1 black-level pass, 2 waiting for host, 3 full-scale pass. A `start` pulse in phase 0 sets both trim words to 0, clears both flags and enters phase 1. `start` has no effect in any other phase.
- R3: Each trial discards SKIP valid samples after a phase entry or a trim update. It then averages the next 2^AVG_LOG2 samples that have `code_vld` high. Cycles with `code_vld` low are not counted, so gaps in the stream leave the result unchanged.
- R4: The black-level pass ends when one window contains both code 0 and code 1. The sequencer then moves to phase 2 and keeps the black-level trim.
- R5: The full-scale pass ends when one window contains both 16383 and 16382. The sequencer then sets `cal_done` and returns to phase 0.
- R6: With a stream that never flickers, a pass also ends when the search direction reverses while the step is 1. The trim is then left on one of the two codes on either side of the switching point.
- R7: The first move from 0 is 2^STEP0_LOG2 (64 by default). A reversal halves the step before the move. The black-level pass moves up while the window mean is 0. The full-scale pass moves up while the mean is below 16383.
- R8: Trim words are two's complement in [-2^(DAC_W-1), 2^(DAC_W-1)-1]. A move past a limit clamps to the limit. A further outward move while at the limit sets `cal_fail`, leaves the trims unchanged, keeps `cal_done` at 0 and returns to phase 0.
- R9: The full-scale trim stays 0 during phases 1 and 2. The black-level trim does not change during phase 3.
- R10: `host_ready` moves phase 2 to phase 3 and has no effect in any other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (phase 0 only) |
| code | input | CODE_W | Converted sample, straight binary |
| code_vld | input | 1 | `code` holds a new sample this cycle |
| host_ready | input | 1 | Host has switched to the saturated input |
| ofs_trim | output | DAC_W | Black-level trim word, two's complement |
| gain_trim | output | DAC_W | Full-scale trim word, two's complement |
| cal_done | output | 1 | Run completed successfully |
| cal_fail | output | 1 | A trim hit its limit without converging |
| cal_phase | output | 2 | Current phase (encoding in R2) |

## Verification
A trim word changes on the clock edge that ends the cycle in which a window completes, which is one register after the last counted sample. Phase transitions on convergence or limit failure follow one cycle later. `start` and `host_ready` act on the very next edge. The bench drives the sample stream at the falling edge from the trim value visible then. For phase changes it polls at falling edges with a bounded wait, and it reads the trim words only after the new phase is visible. Single-edge effects such as the reaction to `start` or `host_ready` are checked at the first falling edge after the pulse.

// File: rtl/calib_pkg.sv
package calib_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_DARK   = 2'd1,
      PH_HOLD   = 2'd2,
      PH_BRIGHT = 2'd3
   } cal_phase_e;

   localparam int unsigned TRIM_OFS  = 0;
   localparam int unsigned TRIM_GAIN = 1;
   localparam int unsigned N_TRIMS   = 2;

endpackage

// File: rtl/calib_window.sv
module calib_window #(
   parameter int CODE_W   = 14,
   parameter int AVG_LOG2 = 4,
   parameter int SKIP     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   input  logic              code_vld,
   input  logic [CODE_W-1:0] tgt,
   input  logic [CODE_W-1:0] adj,
   output logic              win_done,
   output logic [CODE_W-1:0] win_mean,
   output logic              saw_tgt,
   output logic              saw_adj
);

   localparam int SUM_W  = CODE_W + AVG_LOG2;
   localparam int SKIP_W = (SKIP > 1) ? $clog2(SKIP) : 1;
   localparam logic [AVG_LOG2-1:0] ACC_LAST  = AVG_LOG2'((1 << AVG_LOG2) - 1);
   localparam logic [SKIP_W-1:0]   SKIP_LAST = SKIP_W'(SKIP - 1);

   logic [SUM_W-1:0]    sum_q, sum_nx;
   logic [AVG_LOG2-1:0] acc_cnt;
   logic [SKIP_W-1:0]   skip_cnt;
   logic                skipping;
   logic                seen_t_q, seen_a_q, seen_t_nx, seen_a_nx;

   always_comb begin
      sum_nx    = sum_q + SUM_W'(code);
      seen_t_nx = seen_t_q | (code == tgt);
      seen_a_nx = seen_a_q | (code == adj);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q    <= '0;
         acc_cnt  <= '0;
         skip_cnt <= '0;
         skipping <= 1'b1;
         seen_t_q <= 1'b0;
         seen_a_q <= 1'b0;
         win_done <= 1'b0;
         win_mean <= '0;
         saw_tgt  <= 1'b0;
         saw_adj  <= 1'b0;
      end else begin
         win_done <= 1'b0;
         if (!run) begin
            sum_q    <= '0;
            acc_cnt  <= '0;
            skip_cnt <= '0;
            skipping <= 1'b1;
            seen_t_q <= 1'b0;
            seen_a_q <= 1'b0;
         end else if (code_vld) begin
            if (skipping) begin
               if (skip_cnt == SKIP_LAST) begin
                  skipping <= 1'b0;
                  skip_cnt <= '0;
               end else begin
                  skip_cnt <= skip_cnt + 1'b1;
               end
            end else if (acc_cnt == ACC_LAST) begin
               win_done <= 1'b1;
               win_mean <= sum_nx[SUM_W-1:AVG_LOG2];
               saw_tgt  <= seen_t_nx;
               saw_adj  <= seen_a_nx;
               sum_q    <= '0;
               acc_cnt  <= '0;
               skipping <= 1'b1;
               seen_t_q <= 1'b0;
               seen_a_q <= 1'b0;
            end else begin
               sum_q    <= sum_nx;
               acc_cnt  <= acc_cnt + 1'b1;
               seen_t_q <= seen_t_nx;
               seen_a_q <= seen_a_nx;
            end
         end
      end
   end

endmodule

// File: rtl/calib_trim.sv
module calib_trim #(
   parameter int DAC_W      = 9,
   parameter int STEP0_LOG2 = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    init,
   input  logic                    eval,
   input  logic                    up,
   input  logic                    hit,
   output logic signed [DAC_W-1:0] dac,
   output logic                    conv,
   output logic                    lim_fail
);

   localparam int STEP_W = STEP0_LOG2 + 1;
   localparam int EXT_W  = DAC_W + 1;
   localparam logic [STEP_W-1:0]       STEP_INIT = STEP_W'(1) << STEP0_LOG2;
   localparam logic [STEP_W-1:0]       STEP_ONE  = STEP_W'(1);
   localparam logic signed [DAC_W-1:0] DAC_MAX   = DAC_W'((1 << (DAC_W-1)) - 1);
   localparam logic signed [DAC_W-1:0] DAC_MIN   = DAC_W'(1 << (DAC_W-1));
   localparam logic signed [EXT_W-1:0] EXT_MAX   = EXT_W'((1 << (DAC_W-1)) - 1);
   localparam logic signed [EXT_W-1:0] EXT_MIN   = -EXT_W'(1 << (DAC_W-1));

   logic [STEP_W-1:0]       step_q, step_nx;
   logic                    last_up, have_dir, rev;
   logic signed [EXT_W-1:0] cur_ext, delta, cand;
   logic                    over, under;

   always_comb begin
      rev     = have_dir && (up != last_up);
      step_nx = rev ? (step_q >> 1) : step_q;
      cur_ext = {dac[DAC_W-1], dac};
      delta   = signed'({{(EXT_W-STEP_W){1'b0}}, step_nx});
      cand    = up ? (cur_ext + delta) : (cur_ext - delta);
      over    = cand > EXT_MAX;
      under   = cand < EXT_MIN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac      <= '0;
         step_q   <= STEP_INIT;
         last_up  <= 1'b0;
         have_dir <= 1'b0;
         conv     <= 1'b0;
         lim_fail <= 1'b0;
      end else begin
         conv     <= 1'b0;
         lim_fail <= 1'b0;
         if (init) begin
            dac      <= '0;
            step_q   <= STEP_INIT;
            last_up  <= 1'b0;
            have_dir <= 1'b0;
         end else if (eval) begin
            if (hit || (rev && step_q == STEP_ONE)) begin
               conv <= 1'b1;
            end else begin
               last_up  <= up;
               have_dir <= 1'b1;
               step_q   <= step_nx;
               if (over) begin
                  if (dac == DAC_MAX) lim_fail <= 1'b1;
                  else                dac      <= DAC_MAX;
               end else if (under) begin
                  if (dac == DAC_MIN) lim_fail <= 1'b1;
                  else                dac      <= DAC_MIN;
               end else begin
                  dac <= cand[DAC_W-1:0];
               end
            end
         end
      end
   end

endmodule

// File: rtl/calib_seq.sv
module calib_seq
   import calib_pkg::*;
#(
   parameter int CODE_W     = 14,
   parameter int DAC_W      = 9,
   parameter int AVG_LOG2   = 4,
   parameter int SKIP       = 2,
   parameter int STEP0_LOG2 = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [CODE_W-1:0]       code,
   input  logic                    code_vld,
   input  logic                    host_ready,
   output logic signed [DAC_W-1:0] ofs_trim,
   output logic signed [DAC_W-1:0] gain_trim,
   output logic                    cal_done,
   output logic                    cal_fail,
   output logic [1:0]              cal_phase
);

   localparam logic [CODE_W-1:0] ZERO_CODE = '0;
   localparam logic [CODE_W-1:0] ONE_CODE  = CODE_W'(1);
   localparam logic [CODE_W-1:0] FS_CODE   = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] FS_M1     = FS_CODE - ONE_CODE;

   if (CODE_W < 2 || CODE_W > 24) begin : g_bad_code_w
      $error("calib_seq: CODE_W out of range");
   end
   if (AVG_LOG2 < 1 || AVG_LOG2 > 10) begin : g_bad_avg
      $error("calib_seq: AVG_LOG2 out of range");
   end
   if (SKIP < 1) begin : g_bad_skip
      $error("calib_seq: SKIP must be at least 1");
   end
   if (DAC_W < 3 || STEP0_LOG2 < 0 || STEP0_LOG2 > DAC_W - 2) begin : g_bad_trim
      $error("calib_seq: trim width or initial step out of range");
   end

   cal_phase_e phase_q;
   logic              win_run, win_done, saw_tgt, saw_adj, hit, up;
   logic [CODE_W-1:0] win_mean, tgt, adj;
   logic              trim_init;
   logic              t_eval [N_TRIMS];
   logic              t_conv [N_TRIMS];
   logic              t_fail [N_TRIMS];
   logic signed [DAC_W-1:0] t_dac [N_TRIMS];

   always_comb begin
      win_run   = (phase_q == PH_DARK) || (phase_q == PH_BRIGHT);
      trim_init = (phase_q == PH_IDLE) && start;
      if (phase_q == PH_BRIGHT) begin
         tgt = FS_CODE;
         adj = FS_M1;
         up  = (win_mean != FS_CODE);
      end else begin
         tgt = ZERO_CODE;
         adj = ONE_CODE;
         up  = (win_mean == ZERO_CODE);
      end
      hit = saw_tgt && saw_adj;
   end

   calib_window #(
      .CODE_W   (CODE_W),
      .AVG_LOG2 (AVG_LOG2),
      .SKIP     (SKIP)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (win_run),
      .code     (code),
      .code_vld (code_vld),
      .tgt      (tgt),
      .adj      (adj),
      .win_done (win_done),
      .win_mean (win_mean),
      .saw_tgt  (saw_tgt),
      .saw_adj  (saw_adj)
   );

   for (genvar t = 0; t < N_TRIMS; t++) begin : g_trim
      localparam cal_phase_e OWN_PH = (t == TRIM_OFS) ? PH_DARK : PH_BRIGHT;

      assign t_eval[t] = win_done && (phase_q == OWN_PH);

      calib_trim #(
         .DAC_W      (DAC_W),
         .STEP0_LOG2 (STEP0_LOG2)
      ) u_trim (
         .clk      (clk),
         .rst_n    (rst_n),
         .init     (trim_init),
         .eval     (t_eval[t]),
         .up       (up),
         .hit      (hit),
         .dac      (t_dac[t]),
         .conv     (t_conv[t]),
         .lim_fail (t_fail[t])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cal_done <= 1'b0;
         cal_fail <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q  <= PH_DARK;
                  cal_done <= 1'b0;
                  cal_fail <= 1'b0;
               end
            end
            PH_DARK: begin
               if (t_fail[TRIM_OFS]) begin
                  phase_q  <= PH_IDLE;
                  cal_fail <= 1'b1;
               end else if (t_conv[TRIM_OFS]) begin
                  phase_q <= PH_HOLD;
               end
            end
            PH_HOLD: begin
               if (host_ready) phase_q <= PH_BRIGHT;
            end
            PH_BRIGHT: begin
               if (t_fail[TRIM_GAIN]) begin
                  phase_q  <= PH_IDLE;
                  cal_fail <= 1'b1;
               end else if (t_conv[TRIM_GAIN]) begin
                  phase_q  <= PH_IDLE;
                  cal_done <= 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign ofs_trim  = t_dac[TRIM_OFS];
   assign gain_trim = t_dac[TRIM_GAIN];
   assign cal_phase = phase_q;

endmodule

// File: rtl/calib_seq_chk.sv
module calib_seq_chk #(
   parameter int DAC_W = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    host_ready,
   input logic signed [DAC_W-1:0] ofs_trim,
   input logic signed [DAC_W-1:0] gain_trim,
   input logic                    cal_done,
   input logic                    cal_fail,
   input logic [1:0]              cal_phase
);

   assert_gain_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_phase == 2'd1 || cal_phase == 2'd2) |-> (gain_trim == '0));

   assert_ofs_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_phase == 2'd3 && $past(cal_phase) == 2'd3) |-> $stable(ofs_trim));

   assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_done && cal_fail));

   assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_phase == 2'd2 && !host_ready) |=> (cal_phase == 2'd2));

   assert_done_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_done) |-> ($past(cal_phase) == 2'd3));

endmodule

bind calib_seq calib_seq_chk #(.DAC_W(DAC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .ofs_trim   (ofs_trim),
   .gain_trim  (gain_trim),
   .cal_done   (cal_done),
   .cal_fail   (cal_fail),
   .cal_phase  (cal_phase)
);

// File: tb/calib_seq_tb_top.sv
`timescale 1ns/1ps
module calib_seq_tb_top;

   localparam int CODE_W = 14;
   localparam int DAC_W  = 9;
   localparam int FS     = (1 << CODE_W) - 1;
   localparam int TMAX   = (1 << (DAC_W-1)) - 1;
   localparam int TMIN   = -(1 << (DAC_W-1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic host_ready = 1'b0;
   logic [CODE_W-1:0] code = '0;
   logic code_vld = 1'b0;
   logic signed [DAC_W-1:0] ofs_trim, gain_trim;
   logic cal_done, cal_fail;
   logic [1:0] cal_phase;

   always #2.5 clk = ~clk;

   calib_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .code(code), .code_vld(code_vld),
      .host_ready(host_ready), .ofs_trim(ofs_trim), .gain_trim(gain_trim),
      .cal_done(cal_done), .cal_fail(cal_fail), .cal_phase(cal_phase)
   );

   int n_chk = 0, n_bad = 0;
   int mode = 0, bd = 0, sd = 1, bg = 0, sg = 1, duty = 1;
   bit dith = 1'b1, dth = 1'b0;
   int dcnt = 0, gviol = 0, oviol = 0, hn = 0;
   int hist [2];
   int ofs_prev = 0, ph_prev = 0;
   bit finished = 1'b0;

   function automatic int clampc(int v);
      if (v < 0) return 0;
      if (v > FS) return FS;
      return v;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // plant model and monitors, all at the falling edge
   initial forever begin
      @(negedge clk);
      if ((cal_phase == 2'd1 || cal_phase == 2'd2) && gain_trim != '0) gviol++;
      if (cal_phase == 2'd3 && ph_prev == 3 && int'(ofs_trim) != ofs_prev) oviol++;
      if (cal_phase == 2'd1 && int'(ofs_trim) != ofs_prev && hn < 2) begin
         hist[hn] = int'(ofs_trim);
         hn++;
      end
      ofs_prev = int'(ofs_trim);
      ph_prev  = int'(cal_phase);
      if (dcnt >= duty - 1) begin
         int v;
         dcnt = 0;
         if (mode == 0) v = bd + sd * int'(ofs_trim);
         else           v = bg + sg * int'(gain_trim);
         if (dith) begin
            v = v + int'(dth);
            dth = ~dth;
         end
         code     = CODE_W'(clampc(v));
         code_vld = 1'b1;
      end else begin
         dcnt++;
         code_vld = 1'b0;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   task automatic pulse_start();
      hn = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_ready();
      host_ready = 1'b1;
      @(negedge clk);
      host_ready = 1'b0;
   endtask

   task automatic wait_ph(int p);
      int k = 0;
      while (int'(cal_phase) != p && k < 40000) begin
         @(negedge clk);
         k++;
      end
   endtask

   // largest trim whose dark code still reads 0 (search moves up there)
   function automatic int dark_edge();
      int e = TMIN;
      for (int x = TMIN; x <= TMAX; x++) if (clampc(bd + sd * x) == 0) e = x;
      return e;
   endfunction

   function automatic int bright_edge();
      int e = TMIN;
      for (int x = TMIN; x <= TMAX; x++) if (clampc(bg + sg * x) < FS) e = x;
      return e;
   endfunction

   initial begin
      int e;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ofs_trim", int'(ofs_trim), 0);
      chk("R1 gain_trim", int'(gain_trim), 0);
      chk("R1 flags", {cal_done, cal_fail}, 0);
      chk("R1 phase", int'(cal_phase), 0);

      // A: flickering stream, full run
      mode = 0; bd = -37; sd = 1; bg = FS - 1 + 77; sg = 1; dith = 1; duty = 1;
      pulse_start();
      chk("R2 phase after start", int'(cal_phase), 1);
      chk("R2 trims zero", int'(ofs_trim) + int'(gain_trim), 0);
      pulse_ready();
      chk("R10 ready ignored in phase 1", int'(cal_phase), 1);
      wait_ph(2);
      chk("R4 reached wait phase", int'(cal_phase), 2);
      chk("R4 black trim", int'(ofs_trim), 37);
      chk("R7 first move", hist[0], 64);
      chk("R7 halved after reversal", hist[1], 32);
      repeat (5) @(negedge clk);
      chk("R10 holds without ready", int'(cal_phase), 2);
      pulse_start();
      chk("R2 start ignored in phase 2", int'(cal_phase), 2);
      chk("R2 trim kept", int'(ofs_trim), 37);
      mode = 1;
      pulse_ready();
      chk("R10 ready enters phase 3", int'(cal_phase), 3);
      wait_ph(0);
      chk("R5 done", int'(cal_done), 1);
      chk("R5 fail clear", int'(cal_fail), 0);
      chk("R5 gain trim", int'(gain_trim), -77);
      chk("R9 black trim unchanged", int'(ofs_trim), 37);
      chk("R9 gain parked", gviol, 0);
      chk("R9 black frozen", oviol, 0);

      // B: no flicker, reversal at unit step
      mode = 0; bd = -50; sd = 3; bg = 16300; sg = 2; dith = 0;
      pulse_start();
      wait_ph(2);
      e = dark_edge();
      chk("R6 black pass ends", int'(cal_phase), 2);
      chk("R6 black trim at edge", int'(int'(ofs_trim) == e || int'(ofs_trim) == e + 1), 1);
      mode = 1;
      pulse_ready();
      wait_ph(0);
      e = bright_edge();
      chk("R6 done", int'(cal_done), 1);
      chk("R6 gain trim at edge", int'(int'(gain_trim) == e || int'(gain_trim) == e + 1), 1);
      chk("R9 gain parked B", gviol, 0);

      // C: sparse valid samples give the same result
      mode = 0; bd = -100; sd = 1; bg = FS - 1 - 5; sg = 1; dith = 1; duty = 3;
      pulse_start();
      wait_ph(2);
      chk("R3 sparse black trim", int'(ofs_trim), 100);
      mode = 1;
      pulse_ready();
      wait_ph(0);
      chk("R3 sparse gain trim", int'(gain_trim), 5);
      chk("R3 sparse done", int'(cal_done), 1);
      duty = 1;

      // D: black level unreachable
      mode = 0; bd = 20000; sd = 1; dith = 1;
      pulse_start();
      chk("R2 start clears done", int'(cal_done), 0);
      wait_ph(0);
      chk("R8 fail set", int'(cal_fail), 1);
      chk("R8 done clear", int'(cal_done), 0);
      chk("R8 black trim at min", int'(ofs_trim), TMIN);
      chk("R8 gain untouched", int'(gain_trim), 0);

      // E: full scale unreachable
      mode = 0; bd = -10; bg = 0; sg = 1;
      pulse_start();
      chk("R2 start clears fail", int'(cal_fail), 0);
      chk("R2 trims reset", int'(ofs_trim), 0);
      wait_ph(2);
      chk("R4 black trim E", int'(ofs_trim), 10);
      mode = 1;
      pulse_ready();
      wait_ph(0);
      chk("R8 gain fail set", int'(cal_fail), 1);
      chk("R8 gain trim at max", int'(gain_trim), TMAX);
      chk("R8 black kept", int'(ofs_trim), 10);
      repeat (10) @(negedge clk);
      chk("R8 trims hold after fail", int'(gain_trim), TMAX);

      summary();
   end

endmodule